// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Timer with Conversion Trigger

This block generates an edge-aligned pulse-width-modulated output from a free-running up-counter. The counter runs from zero to a programmable wrap value, so one period lasts the wrap value plus one prescaled tick. The prescaler divides the clock by 1, 2, 4 or 8. The output is high while the counter is below the active compare value. As a result, a compare of zero holds the output low for the whole period, and a compare above the wrap value holds it high for the whole period.

A new compare value is first written into a holding register. It is copied into the active compare register only when the counter wraps, so the output never shows a partly updated period. The wrap value input is sampled at the same moment. Each wrap sets a sticky overflow flag, which stays set until a clear strobe arrives. When enabled, an interrupt request follows the flag. Each wrap also produces a one-cycle start pulse, so exactly one external conversion is requested per period. Its result can be written back as the next compare value.

Top module: `pwm_sample_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it: the counter is 0, the held and active compare values are 0, the flag is clear, and `pwm_out`, `ovf_irq` and `conv_start` are low.
- R2: The counter advances once per prescaled tick. It counts from 0 up to the active wrap value and then returns to 0. One period therefore lasts (wrap+1)·2^`psc_sel` clock cycles, where `psc_sel` values 0, 1, 2 and 3 select divide-by 1, 2, 4 and 8.
- R3: `pwm_out` is high exactly while counter < active compare. With compare D ≤ wrap+1, a period contains D·2^`psc_sel` high cycles.
- R4: An active compare of 0 keeps `pwm_out` low for the whole period. An active compare greater than the wrap value keeps it high for the whole period, for example wrap 1022 with compare 1023.
- R5: A `duty_wr` pulse only loads the holding register. The active compare takes the held value at the next wrap. A write in the same cycle as the wrap is taken directly.
- R6: `ovf_flag` sets on every wrap and then stays set until a `flag_clr` cycle.
- R7: If `flag_clr` and a wrap fall in the same cycle, the flag ends up set.
- R8: `ovf_irq` is high exactly when `ovf_flag` and `irq_en` are both high.
- R9: `conv_start` is high for the single cycle that follows each wrap, which is the first cycle of the new period. It pulses once per period.
- R10: The `modulo` input is sampled during reset and at each wrap. A change made mid-period first affects the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_sel | input | 2 | Prescaler select, divide by 2^psc_sel |
| modulo | input | 16 | Counter wrap value |
| duty_wr | input | 1 | Load strobe for the holding compare register |
| duty_data | input | 16 | Compare value to hold |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Enables the interrupt request |
| pwm_out | output | 1 | PWM output |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
A wrong counter or prescaler state shows up within one period, in two ways. The spacing of `conv_start` pulses drifts from (wrap+1)·2^`psc_sel`. The count of high cycles per period also departs from D·2^`psc_sel`. A compare value that reaches the active register too early is visible in the very period in which it was written, because that period shows the new high time instead of the old one. Flag errors, such as a lost set, a clear that wins over a set, or a missing hold, are visible on `ovf_flag` and `ovf_irq` within one cycle of the wrap or clear. The bench compares all four outputs against a behavioural model on every cycle, so each of these errors is caught in the cycle where it first appears.

// File: rtl/pst_pkg.sv
// Shared defaults for the PWM timer.
// Assumes: counter width and prescaler select width are fixed at elaboration.
package pst_pkg;
    localparam int PST_CNT_W = 16;  // counter, wrap and compare width
    localparam int PST_SEL_W = 2;   // prescaler select width
endpackage

// File: rtl/pst_prescaler.sv
// Prescaler: emits a one-cycle tick every 2^sel clock cycles.
// Assumes: sel may change at any time; the phase counter wraps on the
// first tick after a change, so no state is left out of range.
module pst_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int DIV_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   last_phase;

    // Last phase value of the selected ratio.
    always_comb last_phase = ({{DIV_W{1'b0}}, 1'b1} << sel) - 1'b1;

    // Tick on the last phase of the selected ratio.
    always_comb tick = ({1'b0, phase_q} >= last_phase);

    // Phase counter that restarts on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/pst_counter.sv
// Period counter: counts prescaled ticks from 0 to the active wrap value.
// Assumes: the wrap value is sampled during reset and at each wrap only.
module pst_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] mod_in,
    output logic [W-1:0] cnt,
    output logic [W-1:0] mod_act,
    output logic         ovf
);
    // The counter wraps on a tick taken at (or above) the wrap value.
    always_comb ovf = tick && (cnt >= mod_act);

    // Counter and wrap-value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            mod_act <= mod_in;
        end else if (ovf) begin
            cnt     <= '0;
            mod_act <= mod_in;
        end else if (tick) begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pst_compare.sv
// Compare stage: a holding register for written values and an active
// register reloaded at each wrap; drives the PWM level from the count.
// Assumes: a write in the wrap cycle is forwarded into the active register.
module pst_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ovf,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] duty_act,
    output logic         pwm
);
    logic [W-1:0] duty_hold;

    // Holding register, loaded by every write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  duty_hold <= '0;
        else if (wr) duty_hold <= wdata;
    end

    // Active register, reloaded only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   duty_act <= '0;
        else if (ovf) duty_act <= wr ? wdata : duty_hold;
    end

    // High while the count is below the active compare value.
    always_comb pwm = (cnt < duty_act);
endmodule

// File: rtl/pwm_sample_timer.sv
// Top level: prescaler, period counter and compare stage, plus the sticky
// overflow flag, interrupt request and conversion start pulse.
// Assumes: synchronous active-low reset; all inputs are synchronous to clk.
module pwm_sample_timer
    import pst_pkg::*;
#(
    parameter int CNT_W = PST_CNT_W,
    parameter int SEL_W = PST_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic [CNT_W-1:0] modulo,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_data,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             ovf_irq,
    output logic             conv_start
);
    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_act;
    logic [CNT_W-1:0] duty_act;

    pst_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (psc_sel),
        .tick  (tick)
    );

    pst_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mod_in  (modulo),
        .cnt     (cnt_q),
        .mod_act (mod_act),
        .ovf     (ovf)
    );

    pst_compare #(.W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf),
        .wr       (duty_wr),
        .wdata    (duty_data),
        .cnt      (cnt_q),
        .duty_act (duty_act),
        .pwm      (pwm_out)
    );

    // Sticky flag: a wrap sets it and wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (ovf)      ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    // Conversion start pulse in the first cycle of each new period.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= ovf;
    end

    // Interrupt request gated by its enable.
    always_comb ovf_irq = ovf_flag && irq_en;
endmodule

// File: rtl/pst_checker.sv
// Checker for pwm_sample_timer, attached by bind below.
// Assumes: it observes the top ports and a few signals between submodules.
module pst_checker #(
    parameter int W = 16,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] psc_sel,
    input logic             flag_clr,
    input logic             conv_start,
    input logic             ovf_flag,
    input logic             ovf_irq,
    input logic             ovf,
    input logic [W-1:0]     cnt,
    input logic [W-1:0]     mod_act,
    input logic [W-1:0]     duty_act
);
    // Count never passes the active wrap value.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mod_act);

    // Active compare only changes at a wrap.
    p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(duty_act));

    // Flag holds without a clear.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    // Start pulse implies the flag was set at the same wrap, clear or not.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ovf_flag);

    // Interrupt request never without the flag.
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_flag);

    // With any division above 1 the start pulse lasts one cycle.
    p_conv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && (psc_sel != '0)) |=> !conv_start);
endmodule

bind pwm_sample_timer pst_checker #(.W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psc_sel    (psc_sel),
    .flag_clr   (flag_clr),
    .conv_start (conv_start),
    .ovf_flag   (ovf_flag),
    .ovf_irq    (ovf_irq),
    .ovf        (ovf),
    .cnt        (cnt_q),
    .mod_act    (mod_act),
    .duty_act   (duty_act)
);

// File: tb/tb_pwm_sample_timer.sv
module tb_pwm_sample_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  psc_sel = 2'd0;
    logic [15:0] modulo = 16'd9;
    logic        duty_wr = 1'b0;
    logic [15:0] duty_data = 16'd0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b1;
    logic        pwm_out, ovf_flag, ovf_irq, conv_start;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwm_sample_timer dut (
        .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .modulo(modulo),
        .duty_wr(duty_wr), .duty_data(duty_data), .flag_clr(flag_clr),
        .irq_en(irq_en), .pwm_out(pwm_out), .ovf_flag(ovf_flag),
        .ovf_irq(ovf_irq), .conv_start(conv_start)
    );

    // Behavioural reference model
    int m_pre, m_cnt, m_mod, m_hold, m_act, m_div;
    bit m_flag, m_conv, m_tick, m_wrap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_mod = int'(modulo);
            m_hold = 0; m_act = 0; m_flag = 0; m_conv = 0;
        end else begin
            m_div  = 1 << psc_sel;
            m_tick = (m_pre + 1 >= m_div);
            m_pre  = m_tick ? 0 : m_pre + 1;
            m_wrap = m_tick && (m_cnt >= m_mod);
            if (m_wrap) begin
                m_cnt = 0;
                m_mod = int'(modulo);
                m_act = duty_wr ? int'(duty_data) : m_hold;
            end else if (m_tick) begin
                m_cnt = m_cnt + 1;
            end
            if (duty_wr) m_hold = int'(duty_data);
            if (m_wrap) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_conv = m_wrap;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R3 pwm_out vs model", int'(pwm_out), int'(m_cnt < m_act));
            chk("R6 ovf_flag vs model", int'(ovf_flag), int'(m_flag));
            chk("R8 ovf_irq vs model", int'(ovf_irq), int'(m_flag && irq_en));
            chk("R9 conv_start vs model", int'(conv_start), int'(m_conv));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_conv();
        do step(); while (!conv_start);
    endtask

    // Measure one period starting at a start pulse; optionally change inputs there
    task automatic measure(input bit wr, input int d, input int nm, input int np,
                           output int len, output int hi);
        if (!conv_start) wait_conv();
        if (wr) begin duty_wr = 1'b1; duty_data = d[15:0]; end
        if (nm >= 0) modulo = nm[15:0];
        if (np >= 0) psc_sel = np[1:0];
        len = 0; hi = 0;
        do begin
            len++;
            hi += int'(pwm_out);
            step();
            duty_wr = 1'b0;
        end while (!conv_start);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: run hung, R2 periods never completed");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, hi;
        step(); step();
        chk_on = 1'b1;
        // R1: reset state with interrupt enabled
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        chk("R1 ovf_flag in reset", int'(ovf_flag), 0);
        chk("R1 ovf_irq in reset", int'(ovf_irq), 0);
        chk("R1 conv_start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        step();
        chk("R1 pwm_out after reset", int'(pwm_out), 0);
        irq_en = 1'b0;

        // R5: write lands in holding register; old compare 0 still active
        measure(1'b1, 4, -1, -1, len, hi);
        chk("R2 period length wrap 9", len, 10);
        chk("R5 old compare kept", hi, 0);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R3 high cycles compare 4", hi, 4);
        measure(1'b1, 7, -1, -1, len, hi);
        chk("R5 compare 7 not yet active", hi, 4);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R3 high cycles compare 7", hi, 7);

        // R4: 0% and 100%
        measure(1'b1, 0, -1, -1, len, hi);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R4 compare 0 all low", hi, 0);
        measure(1'b1, 12, -1, -1, len, hi);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R4 compare above wrap all high", hi, len);

        // R10: wrap change applies one period later
        measure(1'b0, 0, 4, -1, len, hi);
        chk("R10 old wrap still used", len, 10);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R10 new wrap 4 length", len, 5);
        chk("R4 compare 12 over wrap 4", hi, 5);

        // R2: prescaler ratios
        measure(1'b1, 4, 9, -1, len, hi);
        for (int p = 1; p < 4; p++) begin
            measure(1'b0, 0, -1, p, len, hi);
            measure(1'b0, 0, -1, -1, len, hi);
            chk("R2 prescaled period", len, 10 << p);
            chk("R3 prescaled high time", hi, 4 << p);
        end
        measure(1'b0, 0, -1, 0, len, hi);

        // R4: full-scale cases
        measure(1'b1, 1023, 1022, -1, len, hi);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R2 period wrap 1022", len, 1023);
        chk("R4 compare 1023 wrap 1022 full high", hi, 1023);
        measure(1'b0, 0, 1023, -1, len, hi);
        measure(1'b0, 0, -1, -1, len, hi);
        chk("R2 period wrap 1023", len, 1024);
        chk("R3 compare 1023 wrap 1023", hi, 1023);
        measure(1'b1, 4, 9, -1, len, hi);
        measure(1'b0, 0, -1, -1, len, hi);

        // R9: pulse lasts one cycle
        chk("R9 conv_start at period start", int'(conv_start), 1);
        step();
        chk("R9 conv_start drops", int'(conv_start), 0);

        // R8: interrupt gating
        chk("R8 irq masked", int'(ovf_irq), 0);
        irq_en = 1'b1;
        step();
        chk("R8 irq follows flag", int'(ovf_irq), 1);

        // R6: clear and hold
        wait_conv();
        step(); step(); step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R6 flag cleared", int'(ovf_flag), 0);
        step(); step();
        chk("R6 flag stays clear", int'(ovf_flag), 0);
        wait_conv();
        chk("R6 flag set at wrap", int'(ovf_flag), 1);

        // R7: clear in wrap cycle loses
        for (int i = 0; i < 5; i++) step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R6 flag cleared mid period", int'(ovf_flag), 0);
        step(); step(); step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R7 set wins over clear", int'(ovf_flag), 1);
        chk("R9 pulse with wrap", int'(conv_start), 1);

        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule